// File: doc/BRIEF.md
# Slave DMA Request Handshake Engine

This block sits on the peripheral side of a system DMA link. The host first programs a local start address, a transfer direction, a burst size and a total transfer length. The engine then asks the system DMA controller for service by raising a request line. Each data cycle the controller performs is signalled by a strobe while the acknowledge line is active. On each such cycle the engine moves its local memory address forward by one bus word and subtracts the bytes moved from both the burst and the total byte counts.

Burst size and transfer length are counted in bytes, whatever the bus width. A 16-bit bus therefore needs twice as many data cycles per burst as a 32-bit bus. The request drops on the last data cycle of a burst. It returns only after the acknowledge line has been released, and only if bytes remain. There is no end-of-transfer pin. Completion sets a sticky status bit, which can drive an interrupt when that interrupt is enabled. Both handshake lines have a programmable active level.

Top module: `dma_slave_engine`

## Requirements
- R1: After reset the request pin is low (both handshake lines default to active-high), the bus mode defaults to 32 bits, `irq` and `err` are low and no memory strobe is driven.
- R2: Writing the config register (select 2: bit0 direction, bits 15:8 burst bytes, bits 31:16 length bytes) with a valid setup makes the request active from the next cycle.
- R3: A data cycle is a `xfer_stb` high while the acknowledge line is active and the request phase is open. Each data cycle advances `mem_addr` from the start address (select 1) by 4 in 32-bit mode or by 2 in 16-bit mode. It pulses `mem_we` with `mem_wdata`=`host_wdata` when direction bit0 is 1, and pulses `mem_re` with `host_rdata`=`mem_rdata` when bit0 is 0.
- R4: The request goes inactive in the same cycle as the final data cycle of a burst. A burst spans burst/4 data cycles in 32-bit mode and burst/2 data cycles in 16-bit mode.
- R5: After a burst, the request becomes active again one cycle after the acknowledge line is seen inactive, provided bytes remain.
- R6: When fewer bytes remain than the burst size, the final burst is shortened to the remaining bytes.
- R7: When the byte count runs out, the request drops on that last data cycle and stays inactive until the config register is written again. A config write during a transfer restarts it from the start address.
- R8: Mode register (select 0) bit0=1 makes the request active-high and 0 makes it active-low. Bit1 does the same for the acknowledge line. Bit2=1 selects 16-bit bus mode.
- R9: Strobes while acknowledge is inactive, and writes to the start or mode registers during a transfer, leave `mem_addr` and the remaining byte count unchanged.
- R10: A config write with a misaligned start address (bit0 set in 16-bit mode, bits 1:0 nonzero in 32-bit mode) or a zero burst size sets `err` and keeps the request inactive. A valid config write clears `err`.
- R11: Completion sets a sticky done bit. `irq` is the done bit ANDed with interrupt-enable register (select 3) bit3. Writing 1 to status register (select 4) bit0 clears the done bit.
- R12: A valid config write with zero length raises no request and does not set the done bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| dreq | output | 1 | DMA request, programmable level |
| dack | input | 1 | DMA acknowledge, programmable level |
| xfer_stb | input | 1 | Data-cycle strobe from the system bus |
| host_wdata | input | DATA_W | Data from the system bus |
| host_rdata | output | DATA_W | Data to the system bus |
| mem_addr | output | ADDR_W | Local memory byte address |
| mem_we | output | 1 | Local memory write strobe |
| mem_re | output | 1 | Local memory read strobe |
| mem_wdata | output | DATA_W | Local memory write data |
| mem_rdata | input | DATA_W | Local memory read data |
| irq | output | 1 | Completion interrupt |
| err | output | 1 | Configuration error flag |

## Verification
The embedded assertions check on every cycle several invariants. The request stays inactive while the engine waits for the acknowledge line to be released, after completion, and while the error flag is set. A finished burst always closes the request phase. The address and byte count move only on a data cycle or a re-arm. The burst count never exceeds the remaining count, and the done bit stays set until it is cleared. Only the bench's scenarios can show the exact request timing for each burst length, the shortened final burst, the step size in each bus mode and the polarity swaps. They also show that bus activity between bursts is ignored, along with re-arming mid-transfer, the error recovery and the zero-length case. The bench shows these by comparing every port against its own behavioural model on every clock.

// File: rtl/dma_slave_pkg.sv
package dma_slave_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_REQ  = 2'd1,
    PH_GAP  = 2'd2,
    PH_DONE = 2'd3
  } phase_t;

  localparam logic [2:0] SEL_MODE   = 3'd0;
  localparam logic [2:0] SEL_START  = 3'd1;
  localparam logic [2:0] SEL_CONFIG = 3'd2;
  localparam logic [2:0] SEL_INTEN  = 3'd3;
  localparam logic [2:0] SEL_STATUS = 3'd4;

  // bytes carried by one data cycle
  function automatic logic [2:0] step_bytes(input logic bus16);
    return bus16 ? 3'd2 : 3'd4;
  endfunction

  function automatic logic [31:0] min_u(input logic [31:0] a, input logic [31:0] b);
    return (a < b) ? a : b;
  endfunction

  // alignment rule depends on bus width
  function automatic logic start_ok(input logic [1:0] low_bits, input logic bus16);
    return bus16 ? (low_bits[0] == 1'b0) : (low_bits == 2'b00);
  endfunction

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_slave_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int LEN_W   = 16,
  parameter int BURST_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_sel,
  input  logic [31:0]        cfg_wdata,
  input  logic               done_evt,
  output logic               arm,
  output logic [BURST_W-1:0] arm_burst,
  output logic [LEN_W-1:0]   arm_len,
  output logic               req_hi,
  output logic               ack_hi,
  output logic               bus16,
  output logic [ADDR_W-1:0]  start_addr,
  output logic               dir_wr,
  output logic [BURST_W-1:0] burst_bytes,
  output logic               int_en,
  output logic               done_flag
);

  localparam int BURST_LSB = 8;
  localparam int LEN_LSB   = 16;

  logic done_clr;

  assign arm       = cfg_we && (cfg_sel == SEL_CONFIG);
  assign arm_burst = cfg_wdata[BURST_LSB +: BURST_W];
  assign arm_len   = cfg_wdata[LEN_LSB +: LEN_W];
  assign done_clr  = cfg_we && (cfg_sel == SEL_STATUS) && cfg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_hi      <= 1'b1;
      ack_hi      <= 1'b1;
      bus16       <= 1'b0;
      start_addr  <= '0;
      dir_wr      <= 1'b0;
      burst_bytes <= '0;
      int_en      <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_MODE: begin
          req_hi <= cfg_wdata[0];
          ack_hi <= cfg_wdata[1];
          bus16  <= cfg_wdata[2];
        end
        SEL_START:  start_addr <= cfg_wdata[ADDR_W-1:0];
        SEL_CONFIG: begin
          dir_wr      <= cfg_wdata[0];
          burst_bytes <= arm_burst;
        end
        SEL_INTEN:  int_en <= cfg_wdata[3];
        default: ;
      endcase
    end
  end

  // sticky completion bit: a new completion wins over a clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        done_flag <= 1'b0;
    else if (done_evt) done_flag <= 1'b1;
    else if (done_clr) done_flag <= 1'b0;
  end

  assert_done_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> done_flag);
  assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !done_clr) |=> done_flag);

endmodule

// File: rtl/dma_addr_counter.sv
module dma_addr_counter
  import dma_slave_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int LEN_W   = 16,
  parameter int BURST_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm,
  input  logic               bus16,
  input  logic [ADDR_W-1:0]  start_addr,
  input  logic [BURST_W-1:0] arm_burst,
  input  logic [LEN_W-1:0]   arm_len,
  input  logic [BURST_W-1:0] burst_bytes,
  input  logic               beat,
  output logic [ADDR_W-1:0]  cur_addr,
  output logic               last_in_burst,
  output logic               last_total
);

  logic [2:0]         step;
  logic [BURST_W-1:0] burst_left;
  logic [LEN_W-1:0]   remaining;
  logic [LEN_W-1:0]   take;
  logic [LEN_W-1:0]   rem_after;

  assign step          = step_bytes(bus16);
  assign take          = LEN_W'(min_u(32'(step), 32'(burst_left)));
  assign rem_after     = remaining - take;
  assign last_in_burst = 32'(burst_left) <= 32'(step);
  assign last_total    = 32'(remaining) <= 32'(step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr   <= '0;
      remaining  <= '0;
      burst_left <= '0;
    end else if (arm) begin
      cur_addr   <= start_addr;
      remaining  <= arm_len;
      burst_left <= BURST_W'(min_u(32'(arm_burst), 32'(arm_len)));
    end else if (beat) begin
      cur_addr  <= cur_addr + ADDR_W'(step);
      remaining <= rem_after;
      if (last_in_burst)
        burst_left <= BURST_W'(min_u(32'(burst_bytes), 32'(rem_after)));
      else
        burst_left <= burst_left - BURST_W'(take);
    end
  end

  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && !beat) |=> ($stable(cur_addr) && $stable(remaining)));
  assert_burst_fits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    32'(burst_left) <= 32'(remaining));

endmodule

// File: rtl/dma_handshake.sv
module dma_handshake
  import dma_slave_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic arm_ok,
  input  logic arm_len_nz,
  input  logic req_hi,
  input  logic ack_hi,
  input  logic dack,
  input  logic xfer_stb,
  input  logic last_in_burst,
  input  logic last_total,
  output logic dreq,
  output logic beat,
  output logic done_evt,
  output logic err_flag
);

  phase_t phase;
  logic   ack_act;
  logic   burst_end;
  logic   req_int;

  assign ack_act   = (dack == ack_hi);
  assign beat      = (phase == PH_REQ) && ack_act && xfer_stb;
  assign burst_end = beat && last_in_burst;
  assign done_evt  = beat && last_total;
  assign req_int   = (phase == PH_REQ) && !burst_end;
  assign dreq      = req_hi ? req_int : ~req_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      err_flag <= 1'b0;
    end else if (arm) begin
      err_flag <= !arm_ok;
      phase    <= (arm_ok && arm_len_nz) ? PH_REQ : PH_IDLE;
    end else begin
      case (phase)
        PH_REQ:  if (done_evt) phase <= PH_DONE;
                 else if (burst_end) phase <= PH_GAP;
        PH_GAP:  if (!ack_act) phase <= PH_REQ;
        default: ;
      endcase
    end
  end

  assert_burst_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_end && !arm) |=> (phase != PH_REQ));
  assert_gap_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_GAP) |-> !req_int);
  assert_done_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DONE && !arm) |=> (phase == PH_DONE && !req_int));
  assert_err_blocks_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> !req_int);

endmodule

// File: rtl/dma_slave_engine.sv
module dma_slave_engine
  import dma_slave_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int LEN_W   = 16,
  parameter int BURST_W = 8,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic              dreq,
  input  logic              dack,
  input  logic              xfer_stb,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              irq,
  output logic              err
);

  logic               arm, req_hi, ack_hi, bus16, dir_wr, int_en, done_flag;
  logic [BURST_W-1:0] arm_burst, burst_bytes;
  logic [LEN_W-1:0]   arm_len;
  logic [ADDR_W-1:0]  start_addr;
  logic               beat, done_evt, last_in_burst, last_total;
  logic               arm_ok, arm_len_nz;

  dma_cfg_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BURST_W(BURST_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .done_evt(done_evt), .arm(arm),
    .arm_burst(arm_burst), .arm_len(arm_len), .req_hi(req_hi),
    .ack_hi(ack_hi), .bus16(bus16), .start_addr(start_addr),
    .dir_wr(dir_wr), .burst_bytes(burst_bytes), .int_en(int_en),
    .done_flag(done_flag)
  );

  assign arm_ok     = start_ok(start_addr[1:0], bus16) && (arm_burst != '0);
  assign arm_len_nz = (arm_len != '0);

  dma_addr_counter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BURST_W(BURST_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .arm(arm), .bus16(bus16),
    .start_addr(start_addr), .arm_burst(arm_burst), .arm_len(arm_len),
    .burst_bytes(burst_bytes), .beat(beat), .cur_addr(mem_addr),
    .last_in_burst(last_in_burst), .last_total(last_total)
  );

  dma_handshake u_hs (
    .clk(clk), .rst_n(rst_n), .arm(arm), .arm_ok(arm_ok),
    .arm_len_nz(arm_len_nz), .req_hi(req_hi), .ack_hi(ack_hi),
    .dack(dack), .xfer_stb(xfer_stb), .last_in_burst(last_in_burst),
    .last_total(last_total), .dreq(dreq), .beat(beat),
    .done_evt(done_evt), .err_flag(err)
  );

  assign mem_we     = beat && dir_wr;
  assign mem_re     = beat && !dir_wr;
  assign mem_wdata  = host_wdata;
  assign host_rdata = mem_rdata;
  assign irq        = done_flag && int_en;

  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, mem_re}));

endmodule

// File: tb/dma_slave_engine_bench.sv
module dma_slave_engine_bench;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [2:0] cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic dreq, dack = 0, xfer_stb = 0;
  logic [31:0] host_wdata = 0, host_rdata, mem_wdata, mem_rdata;
  logic [15:0] mem_addr;
  logic mem_we, mem_re, irq, err;

  always #(CLK_P/2) clk = ~clk;

  dma_slave_engine u_dma_slave_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .dreq(dreq), .dack(dack), .xfer_stb(xfer_stb),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .irq(irq), .err(err)
  );

  assign mem_rdata = {16'hC3C3, mem_addr};

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // behavioural reference: 0 idle, 1 requesting, 2 waiting for release, 3 finished
  int m_ph, m_addr, m_rem, m_bl, m_burst, m_start;
  bit m_done, m_err, m_ien, m_dir, m_b16, m_qh, m_kh;

  function automatic int step_of(); return m_b16 ? 2 : 4; endfunction
  function automatic bit beat_now();
    return (m_ph == 1) && (dack == m_kh) && xfer_stb;
  endfunction
  function automatic bit exp_dreq();
    bit on;
    on = (m_ph == 1) && !(beat_now() && m_bl <= step_of());
    return m_qh ? on : !on;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_addr = 0; m_rem = 0; m_bl = 0; m_burst = 0; m_start = 0;
      m_done = 0; m_err = 0; m_ien = 0; m_dir = 0; m_b16 = 0; m_qh = 1; m_kh = 1;
    end else begin
      int st, tk, len;
      bit bt, rel;
      st = step_of(); bt = beat_now(); rel = (dack != m_kh);
      if (cfg_we && cfg_sel == 4 && cfg_wdata[0]) m_done = 0;
      if (bt) begin
        tk = (m_bl < st) ? m_bl : st;
        m_addr = (m_addr + st) & 16'hFFFF;
        if (m_bl <= st) begin
          if (m_rem <= st) begin m_ph = 3; m_done = 1; end
          else m_ph = 2;
          m_rem = m_rem - tk;
          m_bl = (m_burst < m_rem) ? m_burst : m_rem;
        end else begin
          m_rem = m_rem - tk; m_bl = m_bl - tk;
        end
      end else if (m_ph == 2 && rel) m_ph = 1;
      if (cfg_we) begin
        case (cfg_sel)
          0: begin m_qh = cfg_wdata[0]; m_kh = cfg_wdata[1]; m_b16 = cfg_wdata[2]; end
          1: m_start = cfg_wdata[15:0];
          2: begin
            m_dir = cfg_wdata[0]; m_burst = cfg_wdata[15:8]; len = cfg_wdata[31:16];
            m_err = !((m_b16 ? (m_start % 2 == 0) : (m_start % 4 == 0)) && m_burst != 0);
            m_addr = m_start; m_rem = len;
            m_bl = (m_burst < len) ? m_burst : len;
            m_ph = (!m_err && len != 0) ? 1 : 0;
          end
          3: m_ien = cfg_wdata[3];
          default: ;
        endcase
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      #(CLK_P/4);
      chk(dreq == exp_dreq(), "R4 dreq", dreq, exp_dreq());
      chk(mem_addr == m_addr[15:0], "R3 mem_addr", mem_addr, m_addr);
      chk(mem_we == (beat_now() && m_dir), "R3 mem_we", mem_we, beat_now() && m_dir);
      chk(mem_re == (beat_now() && !m_dir), "R3 mem_re", mem_re, beat_now() && !m_dir);
      if (mem_we) chk(mem_wdata == host_wdata, "R3 wdata", mem_wdata, host_wdata);
      if (mem_re) chk(host_rdata == {16'hC3C3, m_addr[15:0]}, "R3 rdata", host_rdata, m_addr);
      chk(irq == (m_done && m_ien), "R11 irq", irq, m_done && m_ien);
      chk(err == m_err, "R10 err", err, m_err);
    end
  end

  task automatic wr(int sel, logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = sel[2:0]; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic beats(int n);
    @(negedge clk); dack = m_kh; xfer_stb = 1;
    for (int i = 1; i < n; i++) begin @(negedge clk); host_wdata = host_wdata + 1; end
    @(negedge clk); xfer_stb = 0; dack = !m_kh;
    repeat (2) @(negedge clk);
  endtask

  task automatic noise();
    @(negedge clk); dack = !m_kh; xfer_stb = 1;
    @(negedge clk); xfer_stb = 0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    host_wdata = 32'h1000;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(dreq == 0 && irq == 0 && err == 0, "R1 reset", {dreq, irq, err}, 0);
    chk(mem_we == 0 && mem_re == 0, "R1 strobes", {mem_we, mem_re}, 0);

    // 32-bit, write direction, 20 bytes in bursts of 8
    wr(3, 32'h8);
    wr(1, 32'h100);
    wr(2, {16'd20, 8'd8, 8'd1}); #1;
    chk(dreq == 1, "R2 request", dreq, 1);
    chk(mem_addr == 16'h100, "R3 start", mem_addr, 16'h100);
    beats(2); #1;
    chk(dreq == 1, "R5 rearm", dreq, 1);
    chk(mem_addr == 16'h108, "R3 step4", mem_addr, 16'h108);
    noise();
    wr(1, 32'h200);
    wr(0, 32'h3); #1;
    chk(mem_addr == 16'h108, "R9 untouched", mem_addr, 16'h108);
    beats(2);
    beats(2); #1;
    chk(mem_addr == 16'h114, "R6 short burst", mem_addr, 16'h114);
    chk(irq == 1, "R11 irq", irq, 1);
    repeat (3) @(negedge clk); #1;
    chk(dreq == 0, "R7 stays low", dreq, 0);
    wr(4, 32'h1); #1;
    chk(irq == 0, "R11 clear", irq, 0);

    // 16-bit, low-active handshake, read direction
    wr(0, 32'h4); #1;
    chk(dreq == 1, "R8 idle level", dreq, 1);
    wr(1, 32'h42);
    wr(2, {16'd10, 8'd6, 8'd0}); #1;
    chk(dreq == 0, "R8 active low", dreq, 0);
    beats(3); #1;
    chk(mem_addr == 16'h48, "R3 step2", mem_addr, 16'h48);
    beats(3); #1;
    chk(mem_addr == 16'h4C, "R6 last burst", mem_addr, 16'h4C);
    chk(irq == 1, "R11 done16", irq, 1);
    wr(4, 32'h1);

    // configuration errors and recovery
    wr(0, 32'h3);
    wr(1, 32'h102);
    wr(2, {16'd8, 8'd4, 8'd1}); #1;
    chk(err == 1 && dreq == 0, "R10 misaligned", {err, dreq}, 2);
    beats(2); #1;
    chk(mem_addr == 16'h102, "R10 no motion", mem_addr, 16'h102);
    wr(1, 32'h100);
    wr(2, {16'd8, 8'd0, 8'd1}); #1;
    chk(err == 1, "R10 zero burst", err, 1);
    wr(2, {16'd8, 8'd4, 8'd1}); #1;
    chk(err == 0 && dreq == 1, "R10 recover", {err, dreq}, 1);
    beats(1);
    wr(2, {16'd8, 8'd4, 8'd1}); #1;
    chk(mem_addr == 16'h100, "R7 rearm", mem_addr, 16'h100);
    beats(1);
    beats(1); #1;
    chk(irq == 1 && dreq == 0, "R7 complete", {irq, dreq}, 2);
    wr(4, 32'h1);

    // zero length
    wr(2, {16'd0, 8'd4, 8'd1}); #1;
    chk(dreq == 0 && err == 0, "R12 no request", {dreq, err}, 0);
    repeat (3) @(negedge clk); #1;
    chk(irq == 0, "R12 no done", irq, 0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule